// File: doc/BRIEF.md
# Serial BCD to Excess-3 Code Converter

This block converts one decimal digit at a time from BCD to Excess-3. The digit enters one bit per clock on `x`, least significant bit first. The matching Excess-3 bit leaves on `z` in the same cycle, so the output is a Mealy output. The block needs four clocks per digit. After the fourth bit it is back in its start state without any framing signal, so digits can follow each other with no gap.

The state is held in three flip-flops. All next-state and output logic comes from one shared sum-of-products plane. An AND plane forms seven product terms over the three state bits and the input. An OR plane then combines those terms into the three next-state bits and the output. Each term feeds exactly one of the four plane outputs.

Top module: `bcd_xs3_serial`

## Requirements
- R1: A synchronous reset, taken at a rising clock edge while `rst` is high, sets the state to 000. Bit 2 of `state` is the first flip-flop, bit 1 the second and bit 0 the third.
- R2: At each rising edge out of reset, the first state bit (state[2]) takes the inverse of the second state bit (state[1]).
- R3: At each rising edge out of reset, the second state bit (state[1]) takes the old value of the first state bit (state[2]).
- R4: At each rising edge out of reset, the third state bit (state[0]) takes s2·s1·s0 + s2·s0'·x' + s2'·s1'·x, where s2..s0 are the current state bits.
- R5: `z` is high exactly when `x` equals state[0]. It responds to `x` within the same cycle.
- R6: When the four bits of a BCD digit 0 to 9 are fed LSB first from the start state, the four `z` bits, read LSB first, form that digit plus three.
- R7: Counting from reset, the state is 000 after every fourth clock, whatever bits were applied, including the unused codes 10 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial BCD bit, LSB first |
| z | output | 1 | Serial Excess-3 bit for the current `x` |
| state | output | 3 | State flip-flops: [2] first, [1] second, [0] third |

## Verification
The assertions assume that `x` holds a defined 0 or 1 at every clock edge. They also assume that `rst` is the only way digit alignment restarts. The stream is driven continuously at falling edges, with no idle cycles that could let the phase drift. It covers every BCD digit, the codes 10 to 15, a free random bit stream, and a reset in the middle of a digit. The bench models the next state from the stated equations and checks every cycle.

// File: rtl/bcd_xs3_pkg.sv
package bcd_xs3_pkg;

    localparam int PLANE_INS   = 4;   // {s2, s1, s0, x}
    localparam int PLANE_TERMS = 7;
    localparam int PLANE_OUTS  = 4;   // {s2 next, s1 next, s0 next, z}
    localparam int STATE_BITS  = 3;
    localparam int DIGIT_BITS  = 4;
    localparam int PHASE_W     = $clog2(DIGIT_BITS);

    typedef logic [PLANE_INS-1:0]   plane_in_t;
    typedef logic [PLANE_TERMS-1:0] term_vec_t;
    typedef logic [PLANE_OUTS-1:0]  plane_out_t;

    typedef struct packed {
        logic s2;
        logic s1;
        logic s0;
    } state_t;

    typedef struct packed {
        state_t st;
        logic   z;
    } step_t;

    // Terms listed from index 6 down to index 0.
    // t0: s1'          t1: s2           t2: s2 s1 s0
    // t3: s2 s0' x'    t4: s2' s1' x    t5: s0' x'     t6: s0 x
    localparam logic [PLANE_TERMS-1:0][PLANE_INS-1:0] TERM_CARE = {
        4'b0011, 4'b0011, 4'b1101, 4'b1011, 4'b1110, 4'b1000, 4'b0100
    };
    localparam logic [PLANE_TERMS-1:0][PLANE_INS-1:0] TERM_VALUE = {
        4'b0011, 4'b0000, 4'b0001, 4'b1000, 4'b1110, 4'b1000, 4'b0000
    };
    localparam logic [PLANE_TERMS-1:0][PLANE_OUTS-1:0] TERM_FEED = {
        4'b0001, 4'b0001, 4'b0010, 4'b0010, 4'b0010, 4'b0100, 4'b1000
    };

endpackage

// File: rtl/bcd_xs3_and_plane.sv
module bcd_xs3_and_plane #(
    parameter int INS   = 4,
    parameter int TERMS = 7,
    parameter logic [TERMS-1:0][INS-1:0] CARE  = '0,
    parameter logic [TERMS-1:0][INS-1:0] VALUE = '0
) (
    input  logic [INS-1:0]   lits,
    output logic [TERMS-1:0] terms
);

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        // A term is true when every cared-about literal matches its value.
        assign terms[t] = ~|((lits ^ VALUE[t]) & CARE[t]);
    end

endmodule

// File: rtl/bcd_xs3_or_plane.sv
module bcd_xs3_or_plane #(
    parameter int TERMS = 7,
    parameter int OUTS  = 4,
    parameter logic [TERMS-1:0][OUTS-1:0] FEED = '0
) (
    input  logic [TERMS-1:0] terms,
    output logic [OUTS-1:0]  sums
);

    for (genvar o = 0; o < OUTS; o++) begin : g_sum
        logic [TERMS-1:0] picked;
        for (genvar t = 0; t < TERMS; t++) begin : g_pick
            assign picked[t] = terms[t] & FEED[t][o];
        end
        assign sums[o] = |picked;
    end

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial
    import bcd_xs3_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  x,
    output logic                  z,
    output logic [STATE_BITS-1:0] state
);

    state_t     state_q;
    step_t      step_d;
    plane_in_t  lits;
    term_vec_t  terms;
    plane_out_t sums;

    assign lits = {state_q.s2, state_q.s1, state_q.s0, x};

    bcd_xs3_and_plane #(
        .INS   (PLANE_INS),
        .TERMS (PLANE_TERMS),
        .CARE  (TERM_CARE),
        .VALUE (TERM_VALUE)
    ) i_and_plane (
        .lits  (lits),
        .terms (terms)
    );

    bcd_xs3_or_plane #(
        .TERMS (PLANE_TERMS),
        .OUTS  (PLANE_OUTS),
        .FEED  (TERM_FEED)
    ) i_or_plane (
        .terms (terms),
        .sums  (sums)
    );

    always_comb begin
        step_d.st.s2 = sums[3];
        step_d.st.s1 = sums[2];
        step_d.st.s0 = sums[1];
        step_d.z     = sums[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= step_d.st;
        end
    end

    assign z     = step_d.z;
    assign state = state_q;

    // Assertion support: cycles since reset, modulo the digit length.
    logic [PHASE_W-1:0] phase_q;
    logic               run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            run_q   <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
            run_q   <= 1'b1;
        end
    end

    AST_S2_INVERTS_S1: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (state_q.s2 == !$past(state_q.s1))); // R2

    AST_S1_TAKES_S2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (state_q.s1 == $past(state_q.s2))); // R3

    AST_S0_TERMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(terms[4:2])); // R4

    AST_Z_MATCHES_INPUT: assert property (@(posedge clk) disable iff (rst)
        z == (x == state_q.s0)); // R5

    AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == '0) |-> (state_q == '0)); // R7

endmodule

// File: tb/test_bcd_xs3_serial.sv
module test_bcd_xs3_serial;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x   = 1'b0;
    logic       z;
    logic [2:0] state;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bcd_xs3_serial i_bcd_xs3_serial (
        .clk   (clk),
        .rst   (rst),
        .x     (x),
        .z     (z),
        .state (state)
    );

    typedef struct {
        logic       x;
        logic       z_exp;
        logic [2:0] s_exp;
        int         digit;
        int         idx;
        bit         bcd;
    } item_t;

    item_t      sb[$];
    logic [2:0] model_s = 3'b000;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] next_s(input logic [2:0] s, input logic xi);
        logic n2, n1, n0;
        n2 = ~s[1];
        n1 = s[2];
        n0 = (s[2] & s[1] & s[0]) | (s[2] & ~s[0] & ~xi) | (~s[2] & ~s[1] & xi);
        return {n2, n1, n0};
    endfunction

    // Driver: called at a falling edge; drives one bit, records expectations.
    task automatic send_bit(input logic b, input int digit, input int idx, input bit bcd);
        item_t it;
        x        = b;
        it.x     = b;
        it.z_exp = (b == model_s[0]);
        it.s_exp = model_s;
        it.digit = digit;
        it.idx   = idx;
        it.bcd   = bcd;
        sb.push_back(it);
        model_s  = next_s(model_s, b);
        @(negedge clk);
    endtask

    task automatic send_word(input int value, input bit bcd);
        for (int i = 0; i < 4; i++) send_bit(value[i], value, i, bcd);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_s = 3'b000;
        check(state == 3'b000, "R1 state after reset", state, 0);
    endtask

    // Monitor: pops one expectation per driven bit and compares.
    logic [3:0] acc = '0;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(z === it.z_exp, "R5 z for current x", z, it.z_exp);
                check(state[2] === it.s_exp[2], "R2 first state bit", state[2], it.s_exp[2]);
                check(state[1] === it.s_exp[1], "R3 second state bit", state[1], it.s_exp[1]);
                check(state[0] === it.s_exp[0], "R4 third state bit", state[0], it.s_exp[0]);
                if (it.idx == 0)
                    check(state == 3'b000, "R7 start state at digit boundary", state, 0);
                acc[it.idx] = z;
                if (it.idx == 3 && it.bcd)
                    check(acc == 4'(it.digit + 3), "R6 digit plus three", acc, it.digit + 3);
            end
        end
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();
        // R6: every BCD digit, twice in a row, back to back.
        for (int d = 0; d < 10; d++) send_word(d, 1'b1);
        for (int d = 9; d >= 0; d--) send_word(d, 1'b1);
        // R7: unused codes still return to the start state.
        for (int d = 10; d < 16; d++) send_word(d, 1'b0);
        // R2, R3, R4, R7: a free random bit stream.
        for (int i = 0; i < 80; i++) send_bit(1'($urandom_range(0, 1)), 0, i % 4, 1'b0);
        // R1: reset in the middle of a digit.
        send_bit(1'b1, 7, 0, 1'b0);
        send_bit(1'b1, 7, 1, 1'b0);
        @(negedge clk);
        #3;
        do_reset();
        for (int d = 0; d < 10; d++) send_word(d, 1'b1);
        @(negedge clk);
        #4;
        check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule